// File: doc/BRIEF.md
# Parallel Display Bus Strobe Sequencer

This block runs single transfers on an 8080-style parallel display bus. Software, or an upstream engine, loads two timing words and a few mode bits. Each request then runs one bus cycle: a command write, a data/parameter write, or a read. During the cycle the block drives the chip-select, write-strobe and read-strobe pins. Each strobe switches on and off at its own programmed tick. On a read, the block samples the incoming data bus at a programmed access tick. A tick is one clock, or two clocks when the coarse-granularity bit is set.

The block checks the timing values as they are loaded. A value that breaks an ordering rule is raised to the smallest legal value, and a status flag records that this happened. The bus cycle does not end before the programmed cycle count has run out. It is followed by a one-clock completion state that pulses `done`.

The control flow is a three-state machine. ST_IDLE waits for a request. When a request arrives, the transition ST_IDLE to ST_RUN latches the kind, the select level and the write data, and clears the tick counter. ST_RUN counts ticks and drives the strobes. When the last tick of the cycle ends, ST_RUN moves to ST_FIN. ST_FIN lasts one clock, asserts `done` and then returns to ST_IDLE.

Top module: `pbus_cycgen`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `bus_oe`, `adj_flag` and `rd_data` are 0, the `bus_cs`, `bus_we` and `bus_re` pins are 1, and `bus_dc` is 0.
- R2: Layout of `cfg_onoff`: chip-select on [3:0], chip-select off [9:4], write-strobe on [13:10], write-strobe off [19:14], read-strobe on [23:20], read-strobe off [29:24]. Layout of `cfg_cycle`: write cycle [5:0], read cycle [11:6], access tick [27:22]. All other bits of both words are ignored.
- R3: Tick 0 is the first clock after a request is accepted. Within a cycle, a strobe is active on every tick t with on <= t < off. The write strobe is active only in write cycles, and the read strobe only in reads.
- R4: When `cfg_coarse` was 1 at load time, every tick lasts two clocks. Otherwise a tick is one clock.
- R5: Legalisation at load time works as follows. An off value at or below its on value becomes on+1. Chip-select off is then raised to at least the larger of the write-strobe off and read-strobe off values. An access tick at or below read-strobe on becomes read-strobe on + 1.
- R6: A write cycle lasts max(write cycle, write-strobe off, chip-select off) ticks. A read cycle lasts max(read cycle, read-strobe off, chip-select off, access+1) ticks, which can reach 64.
- R7: On each accepted load, `adj_flag` becomes 1 if legalisation changed any field and 0 otherwise. It holds that value until the next accepted load.
- R8: A read captures `bus_din` at the end of the first clock of the access tick. The captured value appears on `rd_data` no later than the `done` clock and holds until the next read.
- R9: A request is accepted only in the idle state. From the clock after acceptance, `busy` is 1 through the last tick and through one further clock in which `done` is 1. Requests made while busy, including during the `done` clock, are ignored.
- R10: A `cfg_load` while busy is ignored. A load and a request on the same edge make the new cycle run with the newly loaded timing.
- R11: Polarity bits in `cfg_pol` are: [0] select line, [1] read strobe, [2] write strobe, [3] chip select. With a bit at 0, the strobe is active low and the select line is low for commands and high for data. A 1 inverts that pin.
- R12: During the ticks of a write cycle, `bus_oe` is 1 and `bus_dout` equals the request's write data. `bus_oe` is 0 in reads and whenever the block is not in the tick phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load the timing words and mode bits (idle only) |
| cfg_onoff | input | 32 | Strobe on/off tick word |
| cfg_cycle | input | 32 | Cycle length and access tick word |
| cfg_coarse | input | 1 | Tick lasts two clocks when 1 |
| cfg_pol | input | 4 | Pin polarity inversion bits |
| req_valid | input | 1 | Start a bus cycle (taken when idle) |
| req_read | input | 1 | 1 = read cycle, 0 = write cycle |
| req_dc | input | 1 | 0 = command, 1 = data/parameter |
| req_wdata | input | 16 | Write data for the cycle |
| bus_din | input | 16 | Data bus from the display |
| bus_cs | output | 1 | Chip-select pin |
| bus_we | output | 1 | Write-strobe pin |
| bus_re | output | 1 | Read-strobe pin |
| bus_dc | output | 1 | Command/data select pin |
| bus_oe | output | 1 | Enable for the data bus output driver |
| bus_dout | output | 16 | Data bus to the display |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | 16 | Data captured by the last read |
| adj_flag | output | 1 | Last accepted load was legalised |

## Verification
Two pairs of functions can fall on the same clock edge. The first pair is a new request and the `done` clock of the current cycle. The bench raises `req_valid` exactly in the `done` clock and in a mid-cycle clock, then checks that `busy` stays low on the following clocks, so no cycle was started. The second pair is a timing load and a request. The bench drives both in the same clock from idle, with a configuration whose cycle length differs from the previous one, and checks the per-clock strobe pattern against the new timing. It also loads a legalised configuration while busy and checks that both the flag and the next cycle's length keep the old values.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    parameter int WORD_W = 32;
    parameter int ON_W   = 4;
    parameter int OFF_W  = 6;
    localparam int CYC_W = OFF_W + 1;

    // field positions in the strobe word
    localparam int CS_ON_LSB  = 0;
    localparam int CS_OFF_LSB = 4;
    localparam int WE_ON_LSB  = 10;
    localparam int WE_OFF_LSB = 14;
    localparam int RE_ON_LSB  = 20;
    localparam int RE_OFF_LSB = 24;
    // field positions in the cycle word
    localparam int WCYC_LSB = 0;
    localparam int RCYC_LSB = 6;
    localparam int ACC_LSB  = 22;

    localparam int POL_DC = 0;
    localparam int POL_RE = 1;
    localparam int POL_WE = 2;
    localparam int POL_CS = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [ON_W-1:0]  cs_on;
        logic [ON_W-1:0]  we_on;
        logic [ON_W-1:0]  re_on;
        logic [OFF_W-1:0] cs_off;
        logic [OFF_W-1:0] we_off;
        logic [OFF_W-1:0] re_off;
        logic [OFF_W-1:0] acc;
        logic [CYC_W-1:0] wcyc;
        logic [CYC_W-1:0] rcyc;
    } tcfg_t;

    // legal image of all-zero words
    localparam tcfg_t RESET_CFG = '{
        cs_on:  '0,
        we_on:  '0,
        re_on:  '0,
        cs_off: OFF_W'(1),
        we_off: OFF_W'(1),
        re_off: OFF_W'(1),
        acc:    OFF_W'(1),
        wcyc:   CYC_W'(1),
        rcyc:   CYC_W'(2)
    };

    function automatic logic [OFF_W-1:0] lift_off(input logic [ON_W-1:0] on_t,
                                                  input logic [OFF_W-1:0] off_t);
        if (off_t <= OFF_W'(on_t))
            return OFF_W'(on_t) + OFF_W'(1);
        return off_t;
    endfunction

    function automatic logic [OFF_W-1:0] max_off(input logic [OFF_W-1:0] a,
                                                 input logic [OFF_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [CYC_W-1:0] max_cyc(input logic [CYC_W-1:0] a,
                                                 input logic [CYC_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbus_legalize.sv
module pbus_legalize
    import pbus_pkg::*;
(
    input  logic [WORD_W-1:0] onoff_word,
    input  logic [WORD_W-1:0] cycle_word,
    output tcfg_t             legal,
    output logic              adjusted
);

    logic [ON_W-1:0]  r_cs_on, r_we_on, r_re_on;
    logic [OFF_W-1:0] r_cs_off, r_we_off, r_re_off, r_acc, r_wcyc, r_rcyc;
    logic [OFF_W-1:0] we_off_l, re_off_l, cs_off_a, cs_off_l, acc_l;
    logic [CYC_W-1:0] wcyc_l, rcyc_l;
    logic             unused_bits;

    assign r_cs_on  = onoff_word[CS_ON_LSB  +: ON_W];
    assign r_cs_off = onoff_word[CS_OFF_LSB +: OFF_W];
    assign r_we_on  = onoff_word[WE_ON_LSB  +: ON_W];
    assign r_we_off = onoff_word[WE_OFF_LSB +: OFF_W];
    assign r_re_on  = onoff_word[RE_ON_LSB  +: ON_W];
    assign r_re_off = onoff_word[RE_OFF_LSB +: OFF_W];
    assign r_wcyc   = cycle_word[WCYC_LSB +: OFF_W];
    assign r_rcyc   = cycle_word[RCYC_LSB +: OFF_W];
    assign r_acc    = cycle_word[ACC_LSB  +: OFF_W];

    assign unused_bits = ^{onoff_word[WORD_W-1:RE_OFF_LSB+OFF_W],
                           cycle_word[WORD_W-1:ACC_LSB+OFF_W],
                           cycle_word[ACC_LSB-1:RCYC_LSB+OFF_W]};

    always_comb begin
        we_off_l = lift_off(r_we_on, r_we_off);
        re_off_l = lift_off(r_re_on, r_re_off);
        cs_off_a = lift_off(r_cs_on, r_cs_off);
        cs_off_l = max_off(cs_off_a, max_off(we_off_l, re_off_l));
        acc_l    = lift_off(r_re_on, r_acc);
        wcyc_l   = max_cyc(CYC_W'(r_wcyc),
                           max_cyc(CYC_W'(we_off_l), CYC_W'(cs_off_l)));
        rcyc_l   = max_cyc(max_cyc(CYC_W'(r_rcyc), CYC_W'(re_off_l)),
                           max_cyc(CYC_W'(cs_off_l), CYC_W'(acc_l) + CYC_W'(1)));
    end

    always_comb begin
        legal.cs_on  = r_cs_on;
        legal.we_on  = r_we_on;
        legal.re_on  = r_re_on;
        legal.cs_off = cs_off_l;
        legal.we_off = we_off_l;
        legal.re_off = re_off_l;
        legal.acc    = acc_l;
        legal.wcyc   = wcyc_l;
        legal.rcyc   = rcyc_l;
        adjusted = (we_off_l != r_we_off) || (re_off_l != r_re_off) ||
                   (cs_off_l != r_cs_off) || (acc_l != r_acc) ||
                   (wcyc_l != CYC_W'(r_wcyc)) || (rcyc_l != CYC_W'(r_rcyc));
    end

endmodule

// File: rtl/pbus_cfg_regs.sv
module pbus_cfg_regs
    import pbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_en,
    input  tcfg_t       legal_in,
    input  logic        adj_in,
    input  logic        coarse_in,
    input  logic [3:0]  pol_in,
    output tcfg_t       cfg_q,
    output logic        adj_q,
    output logic        coarse_q,
    output logic [3:0]  pol_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= RESET_CFG;
            adj_q    <= 1'b0;
            coarse_q <= 1'b0;
            pol_q    <= '0;
        end else if (load_en) begin
            cfg_q    <= legal_in;
            adj_q    <= adj_in;
            coarse_q <= coarse_in;
            pol_q    <= pol_in;
        end
    end

endmodule

// File: rtl/pbus_ticker.sv
module pbus_ticker
    import pbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             coarse,
    output logic [CYC_W-1:0] tick,
    output logic             tick_end,
    output logic             first_clk
);

    logic phase;

    assign tick_end  = run && (!coarse || phase);
    assign first_clk = !phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick  <= '0;
            phase <= 1'b0;
        end else if (clear) begin
            tick  <= '0;
            phase <= 1'b0;
        end else if (run) begin
            if (tick_end)
                tick <= tick + CYC_W'(1);
            phase <= coarse ? !phase : 1'b0;
        end
    end

endmodule

// File: rtl/pbus_cycgen.sv
module pbus_cycgen
    import pbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [WORD_W-1:0] cfg_onoff,
    input  logic [WORD_W-1:0] cfg_cycle,
    input  logic              cfg_coarse,
    input  logic [3:0]        cfg_pol,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic              req_dc,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_cs,
    output logic              bus_we,
    output logic              bus_re,
    output logic              bus_dc,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              adj_flag
);

    seq_state_t       state, state_nx;
    tcfg_t            legal_w, cfg;
    logic             adj_w, coarse_q;
    logic [3:0]       pol_q;
    logic             accept, load_en;
    logic [CYC_W-1:0] tick, cyc_len;
    logic             tick_end, first_clk, last_tick, in_run;
    logic             cur_read, cur_dc;
    logic [DATA_W-1:0] cur_wdata, rd_q;
    logic             cs_act, we_act, re_act;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign load_en = (state == ST_IDLE) && cfg_load;
    assign in_run  = (state == ST_RUN);

    pbus_legalize u_legal (
        .onoff_word (cfg_onoff),
        .cycle_word (cfg_cycle),
        .legal      (legal_w),
        .adjusted   (adj_w)
    );

    pbus_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .legal_in  (legal_w),
        .adj_in    (adj_w),
        .coarse_in (cfg_coarse),
        .pol_in    (cfg_pol),
        .cfg_q     (cfg),
        .adj_q     (adj_flag),
        .coarse_q  (coarse_q),
        .pol_q     (pol_q)
    );

    pbus_ticker u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .run       (in_run),
        .coarse    (coarse_q),
        .tick      (tick),
        .tick_end  (tick_end),
        .first_clk (first_clk)
    );

    assign cyc_len   = cur_read ? cfg.rcyc : cfg.wcyc;
    assign last_tick = tick_end && (tick == cyc_len - CYC_W'(1));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_RUN;
            ST_RUN:  if (last_tick) state_nx = ST_FIN;
            ST_FIN:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_read  <= 1'b0;
            cur_dc    <= 1'b0;
            cur_wdata <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cur_read  <= req_read;
                cur_dc    <= req_dc;
                cur_wdata <= req_wdata;
            end
        end
    end

    // read capture at the first clock of the access tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else if (in_run && cur_read && first_clk && (tick == CYC_W'(cfg.acc)))
            rd_q <= bus_din;
    end

    // outputs
    always_comb begin
        cs_act = in_run && (tick >= CYC_W'(cfg.cs_on)) && (tick < CYC_W'(cfg.cs_off));
        we_act = in_run && !cur_read &&
                 (tick >= CYC_W'(cfg.we_on)) && (tick < CYC_W'(cfg.we_off));
        re_act = in_run && cur_read &&
                 (tick >= CYC_W'(cfg.re_on)) && (tick < CYC_W'(cfg.re_off));
        bus_cs   = cs_act ^ !pol_q[POL_CS];
        bus_we   = we_act ^ !pol_q[POL_WE];
        bus_re   = re_act ^ !pol_q[POL_RE];
        bus_dc   = cur_dc ^ pol_q[POL_DC];
        bus_oe   = in_run && !cur_read;
        bus_dout = cur_wdata;
        busy     = (state != ST_IDLE);
        done     = (state == ST_FIN);
        rd_data  = rd_q;
    end

endmodule

// File: rtl/pbus_cycgen_chk.sv
module pbus_cycgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic       bus_cs,
    input logic       bus_re,
    input logic       adj_flag,
    input logic [3:0] pol_q,
    input logic       cur_read
);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_start_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    assert_idle_cs_inactive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_cs == !pol_q[3]));

    assert_no_read_strobe_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cur_read) |-> (bus_re == !pol_q[1]));

    assert_adj_stable_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(adj_flag));

endmodule

bind pbus_cycgen pbus_cycgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .bus_cs    (bus_cs),
    .bus_re    (bus_re),
    .adj_flag  (adj_flag),
    .pol_q     (pol_q),
    .cur_read  (cur_read)
);

// File: tb/pbus_cycgen_test.sv
module pbus_cycgen_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_load, cfg_coarse, req_valid, req_read, req_dc;
    logic [31:0] cfg_onoff, cfg_cycle;
    logic [3:0]  cfg_pol;
    logic [15:0] req_wdata, bus_din, bus_dout, rd_data;
    logic        bus_cs, bus_we, bus_re, bus_dc, bus_oe, busy, done, adj_flag;

    always #4 clk = ~clk;

    pbus_cycgen uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_onoff(cfg_onoff),
        .cfg_cycle(cfg_cycle), .cfg_coarse(cfg_coarse), .cfg_pol(cfg_pol),
        .req_valid(req_valid), .req_read(req_read), .req_dc(req_dc),
        .req_wdata(req_wdata), .bus_din(bus_din), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_re(bus_re), .bus_dc(bus_dc), .bus_oe(bus_oe), .bus_dout(bus_dout),
        .busy(busy), .done(done), .rd_data(rd_data), .adj_flag(adj_flag)
    );

    typedef struct packed {
        int cs_on; int cs_off; int we_on; int we_off; int re_on; int re_off;
        int acc; int wcyc; int rcyc;
        bit coarse; bit [3:0] pol; bit rd; bit dc; bit junk;
        bit [15:0] wdata; bit exp_adj;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{1, 6, 2, 5, 1, 3, 2, 8, 8,       1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 16'hA5C3, 1'b0},
        '{1, 6, 2, 5, 1, 3, 2, 8, 8,       1'b1, 4'h0, 1'b0, 1'b1, 1'b1, 16'h1234, 1'b0},
        '{0, 10, 1, 3, 2, 7, 5, 10, 12,    1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0},
        '{3, 3, 1, 0, 4, 2, 0, 4, 0,       1'b1, 4'h0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1},
        '{0, 2, 0, 1, 0, 1, 1, 3, 2,       1'b0, 4'hF, 1'b0, 1'b1, 1'b0, 16'h00FF, 1'b0},
        '{2, 4, 3, 9, 0, 1, 1, 0, 9,       1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 16'hBEEF, 1'b1},
        '{15, 63, 15, 63, 15, 63, 63, 63, 63, 1'b1, 4'h5, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1}
    };

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // legal timing from the R5/R6 rules
    function automatic vec_t ref_fix(input vec_t v);
        vec_t r = v;
        if (r.we_off <= r.we_on) r.we_off = r.we_on + 1;
        if (r.re_off <= r.re_on) r.re_off = r.re_on + 1;
        if (r.cs_off <= r.cs_on) r.cs_off = r.cs_on + 1;
        if (r.cs_off < r.we_off) r.cs_off = r.we_off;
        if (r.cs_off < r.re_off) r.cs_off = r.re_off;
        if (r.acc <= r.re_on) r.acc = r.re_on + 1;
        if (r.wcyc < r.we_off) r.wcyc = r.we_off;
        if (r.wcyc < r.cs_off) r.wcyc = r.cs_off;
        if (r.rcyc < r.re_off) r.rcyc = r.re_off;
        if (r.rcyc < r.cs_off) r.rcyc = r.cs_off;
        if (r.rcyc < r.acc + 1) r.rcyc = r.acc + 1;
        return r;
    endfunction

    task automatic drive_cfg(input vec_t v);
        cfg_onoff = 32'(v.cs_on) | (32'(v.cs_off) << 4) | (32'(v.we_on) << 10) |
                    (32'(v.we_off) << 14) | (32'(v.re_on) << 20) | (32'(v.re_off) << 24);
        cfg_cycle = 32'(v.wcyc) | (32'(v.rcyc) << 6) | (32'(v.acc) << 22);
        if (v.junk) begin   // R2: bits outside the fields
            cfg_onoff = cfg_onoff | 32'hC000_0000;
            cfg_cycle = cfg_cycle | 32'hF03F_F000;
        end
        cfg_coarse = v.coarse;
        cfg_pol    = v.pol;
    endtask

    task automatic load_cfg(input vec_t v);
        @(negedge clk);
        drive_cfg(v);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        chk(adj_flag == v.exp_adj, "R7", "adj_flag after load", int'(adj_flag), int'(v.exp_adj));
    endtask

    task automatic run_cycle(input vec_t v, input int vi, input bit with_load,
                             input int poke_k, input int load_k, input vec_t lv);
        vec_t g = ref_fix(v);
        int div = v.coarse ? 2 : 1;
        int len = (v.rd ? g.rcyc : g.wcyc) * div;
        bit [15:0] base = 16'h4000 + 16'(vi * 256);
        string stag = v.coarse ? "R3 R4" : "R3";
        if (v.exp_adj) stag = {stag, " R5 R6"};
        req_valid = 1'b1;
        req_read  = v.rd;
        req_dc    = v.dc;
        req_wdata = v.wdata;
        if (with_load) begin
            drive_cfg(v);
            cfg_load = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        cfg_load  = 1'b0;
        req_wdata = ~v.wdata;
        for (int k = 0; k <= len; k++) begin
            int t = k / div;
            bit in_run = (k < len);
            bit e_cs = in_run && t >= g.cs_on && t < g.cs_off;
            bit e_we = in_run && !v.rd && t >= g.we_on && t < g.we_off;
            bit e_re = in_run && v.rd && t >= g.re_on && t < g.re_off;
            bit [2:0] e_pins = {e_cs ^ ~v.pol[3], e_we ^ ~v.pol[2], e_re ^ ~v.pol[1]};
            bit e_oe = in_run && !v.rd;
            chk({bus_cs, bus_we, bus_re} == e_pins, stag, $sformatf("vec %0d strobes k=%0d", vi, k),
                int'({bus_cs, bus_we, bus_re}), int'(e_pins));
            chk(busy == 1'b1 && done == (k == len), "R9", $sformatf("vec %0d busy/done k=%0d", vi, k),
                int'({busy, done}), int'({1'b1, k == len}));
            chk(bus_dc == (v.dc ^ v.pol[0]) && bus_oe == e_oe && (!e_oe || bus_dout == v.wdata),
                "R11 R12", $sformatf("vec %0d dc/oe/dout k=%0d", vi, k),
                int'({bus_dc, bus_oe, bus_dout}), int'({v.dc ^ v.pol[0], e_oe, v.wdata}));
            bus_din   = base + 16'(k);
            req_valid = (k == poke_k);
            cfg_load  = (k == load_k);
            if (k == load_k) drive_cfg(lv);
            @(negedge clk);
        end
        req_valid = 1'b0;
        cfg_load  = 1'b0;
        chk(busy == 1'b0 && done == 1'b0, "R9", $sformatf("vec %0d idle after done", vi),
            int'({busy, done}), 0);
        if (v.rd)
            chk(rd_data == base + 16'(g.acc * div), "R8", $sformatf("vec %0d read capture", vi),
                int'(rd_data), int'(base + 16'(g.acc * div)));
        @(negedge clk);
        chk(busy == 1'b0, "R9", $sformatf("vec %0d no restart", vi), int'(busy), 0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_load = 1'b0; cfg_onoff = '0; cfg_cycle = '0; cfg_coarse = 1'b0;
        cfg_pol = '0; req_valid = 1'b0; req_read = 1'b0; req_dc = 1'b0; req_wdata = '0;
        bus_din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, bus_oe, adj_flag} == 4'b0000 && rd_data == 16'h0, "R1",
            "reset control outputs", int'({busy, done, bus_oe, adj_flag}), 0);
        chk({bus_cs, bus_we, bus_re, bus_dc} == 4'b1110, "R1", "reset pin levels",
            int'({bus_cs, bus_we, bus_re, bus_dc}), 14);

        // table walk: R2 field layout, R3..R8, R11, R12
        for (int vi = 0; vi < NV; vi++) begin
            load_cfg(VT[vi]);
            run_cycle(VT[vi], vi, 1'b0, -1, -1, VT[0]);
        end

        // R9: requests mid-cycle and in the done clock are ignored
        load_cfg(VT[0]);
        run_cycle(VT[0], 7, 1'b0, 3, -1, VT[0]);
        run_cycle(VT[0], 8, 1'b0, 8, -1, VT[0]);

        // R10: load while busy is ignored
        run_cycle(VT[0], 9, 1'b0, -1, 2, VT[5]);
        chk(adj_flag == 1'b0, "R10", "flag after busy load", int'(adj_flag), 0);
        run_cycle(VT[0], 10, 1'b0, -1, -1, VT[0]);

        // R10: load and request on the same edge take the new timing
        run_cycle(VT[4], 11, 1'b1, -1, -1, VT[0]);
        chk(adj_flag == VT[4].exp_adj, "R10", "flag after joint load", int'(adj_flag),
            int'(VT[4].exp_adj));
        run_cycle(VT[5], 12, 1'b1, -1, -1, VT[0]);
        chk(adj_flag == VT[5].exp_adj, "R7 R10", "flag after joint legalised load",
            int'(adj_flag), int'(VT[5].exp_adj));

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule